// File: doc/BRIEF.md
# MII Management Frame Engine

This block is a management-interface master. It runs one read or one write transaction to an external PHY register over a management clock and a bidirectional data line. The host places a request for one cycle. The request carries a 5-bit PHY address, a 5-bit register address, a direction flag and, for writes, a 16-bit data word.

The engine first sends a run of preamble ones, then the frame. On a read, it releases the data line for the turnaround and the data field, and it collects the 16 bits the PHY returns. After the frame it runs one idle clock with the line released. It then lowers `busy` and, one cycle later, pulses `done`. When the request was a read, `rdata` holds the result at that point.

The data line is driven through three pins: an output enable, an output value and an input value. An active-low PHY reset pin follows a host request bit.

Top module: `mgmt_frame_engine`

## Requirements
- R1: While `rst` is high, and in the cycle after any reset, `busy`, `done`, `mdc`, `mdio_oe` and `mdio_o` are 0. A reset in the middle of a transaction abandons it.
- R2: Each transaction begins with `PRE_LEN` bit times in which `mdio_oe` and `mdio_o` are both 1.
- R3: After the preamble, the line carries the start pattern 0 then 1. Next comes the opcode: 1 then 0 for a read, 0 then 1 for a write.
- R4: After the opcode come the 5-bit PHY address and then the 5-bit register address, each sent most significant bit first, with `mdio_oe` high.
- R5: On a write, the turnaround bit times carry 1 then 0, and the 16 data bits follow most significant bit first. `mdio_oe` stays high for the whole frame.
- R6: On a read, `mdio_oe` is 0 for both turnaround bit times and all 16 data bit times. `mdio_i` is sampled at each rising `mdc` of the data field, first bit into bit 15 of `rdata`.
- R7: `mdc` has a period of 2*`DIV` system clocks while busy. `mdio_o` and `mdio_oe` change only in cycles where `mdc` is low.
- R8: After the last frame bit, the engine runs one more `mdc` period with `mdio_oe` low, for `PRE_LEN`+33 rising edges in total. `busy` then falls, and `done` is high for exactly one cycle, starting one cycle after `busy` falls.
- R9: A request presented while `busy` is high is ignored. The transaction in progress is unchanged and no second transaction follows.
- R10: A write transaction leaves `rdata` unchanged.
- R11: `phy_rst_n` is the inverse of `phy_rst_req`, registered with one cycle of latency, and it is 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a transaction (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| phy_rst_req | input | 1 | Request to hold the PHY in reset |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read result |
| mdc | output | 1 | Management clock |
| mdio_oe | output | 1 | Data line output enable |
| mdio_o | output | 1 | Data line output value |
| mdio_i | input | 1 | Data line input value |
| phy_rst_n | output | 1 | Active-low PHY reset |

## Verification
Two situations are the hardest to reach from the ports: a fresh request arriving in the middle of a frame, and a reset cutting a frame short. The stimulus handles both by counting rising `mdc` edges as it watches the line. At the tenth edge it drives a conflicting request with different addresses and direction. In another run it raises reset some thirty cycles into a read. The bench also plays the PHY. It drives the response bits after each rising edge, so every read value arrives through the real turnaround timing.

// File: rtl/mfe_pkg.sv
package mfe_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = 32;
    // bits of the frame that are driven on a read (start, opcode, addresses)
    localparam int RD_DRIVEN  = 14;
    // first data bit position within the frame
    localparam int DATA_POS   = 16;

    localparam logic [1:0] START_PAT = 2'b01;
    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] TA_WRITE  = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } eng_state_t;

    typedef struct packed {
        logic              write;
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
        logic [DATA_W-1:0] wdata;
    } mgmt_req_t;

    typedef struct packed {
        logic oe;
        logic dout;
        logic capture;
    } pin_drive_t;

    function automatic logic [FRAME_BITS-1:0] build_frame(input mgmt_req_t r);
        logic [1:0]        opc;
        logic [1:0]        ta;
        logic [DATA_W-1:0] dat;
        opc = r.write ? OPC_WRITE : OPC_READ;
        ta  = r.write ? TA_WRITE : 2'b00;
        dat = r.write ? r.wdata : '0;
        return {START_PAT, opc, r.phy, r.regad, ta, dat};
    endfunction

endpackage

// File: rtl/mfe_clkgen.sv
module mfe_clkgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic mdc,
    output logic rise_nxt,
    output logic fall_nxt
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = run && (cnt == LAST);
    assign rise_nxt = wrap && !mdc;
    assign fall_nxt = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mfe_bitplan.sv
module mfe_bitplan
    import mfe_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int IDX_W   = 7
) (
    input  logic [IDX_W-1:0]      idx,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  write,
    output pin_drive_t            drv
);
    always_comb begin
        int i;
        int pos;
        i   = int'(idx);
        pos = i - PRE_LEN;
        drv = '0;
        if (i < PRE_LEN) begin
            drv.oe   = 1'b1;
            drv.dout = 1'b1;
        end else if (pos < FRAME_BITS) begin
            drv.oe      = write || (pos < RD_DRIVEN);
            drv.dout    = drv.oe ? frame[5'(FRAME_BITS - 1 - pos)] : 1'b0;
            drv.capture = !write && (pos >= DATA_POS);
        end
    end
endmodule

// File: rtl/mfe_capture.sv
module mfe_capture #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] data
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data <= '0;
        end else if (shift_en) begin
            data <= {data[W-2:0], din};
        end
    end
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
    import mfe_pkg::*;
#(
    parameter int DIV     = 4,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    input  logic        phy_rst_req,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_oe,
    output logic        mdio_o,
    input  logic        mdio_i,
    output logic        phy_rst_n
);
    localparam int TOTAL = PRE_LEN + FRAME_BITS + 1;
    localparam int IDX_W = $clog2(TOTAL + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

    eng_state_t            state;
    logic [IDX_W-1:0]      idx;
    logic [FRAME_BITS-1:0] frame;
    logic                  is_wr;
    logic                  oe_q, o_q, done_q, prst_n_q;
    logic                  run, rise_nxt, fall_nxt;
    mgmt_req_t             req;
    logic [IDX_W-1:0]      nxt_idx;
    logic [FRAME_BITS-1:0] nxt_frame;
    logic                  nxt_wr;
    pin_drive_t            drv_nxt, drv_cur;

    assign req = '{write: req_write, phy: req_phy, regad: req_reg, wdata: req_wdata};
    assign run = (state == ST_RUN);

    assign nxt_idx   = run ? idx + 1'b1 : '0;
    assign nxt_frame = run ? frame : build_frame(req);
    assign nxt_wr    = run ? is_wr : req_write;

    mfe_clkgen #(.DIV(DIV)) u_clk (
        .clk(clk), .rst(rst), .run(run),
        .mdc(mdc), .rise_nxt(rise_nxt), .fall_nxt(fall_nxt)
    );

    mfe_bitplan #(.PRE_LEN(PRE_LEN), .IDX_W(IDX_W)) u_plan_nxt (
        .idx(nxt_idx), .frame(nxt_frame), .write(nxt_wr), .drv(drv_nxt)
    );

    mfe_bitplan #(.PRE_LEN(PRE_LEN), .IDX_W(IDX_W)) u_plan_cur (
        .idx(idx), .frame(frame), .write(is_wr), .drv(drv_cur)
    );

    mfe_capture #(.W(DATA_W)) u_cap (
        .clk(clk), .rst(rst),
        .shift_en(run && rise_nxt && drv_cur.capture),
        .din(mdio_i), .data(rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            frame    <= '0;
            is_wr    <= 1'b0;
            oe_q     <= 1'b0;
            o_q      <= 1'b0;
            done_q   <= 1'b0;
            prst_n_q <= 1'b0;
        end else begin
            prst_n_q <= ~phy_rst_req;
            done_q   <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state <= ST_RUN;
                        idx   <= '0;
                        frame <= nxt_frame;
                        is_wr <= req_write;
                        oe_q  <= drv_nxt.oe;
                        o_q   <= drv_nxt.dout;
                    end
                end
                ST_RUN: begin
                    if (fall_nxt) begin
                        if (idx == LAST_IDX) begin
                            state <= ST_FIN;
                            oe_q  <= 1'b0;
                            o_q   <= 1'b0;
                        end else begin
                            idx  <= nxt_idx;
                            oe_q <= drv_nxt.oe;
                            o_q  <= drv_nxt.dout;
                        end
                    end
                end
                ST_FIN: begin
                    done_q <= 1'b1;
                    state  <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy      = run;
    assign done      = done_q;
    assign mdio_oe   = oe_q;
    assign mdio_o    = o_q;
    assign phy_rst_n = prst_n_q;
endmodule

// File: rtl/mfe_checker.sv
module mfe_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic done,
    input logic mdc,
    input logic mdio_oe,
    input logic mdio_o,
    input logic phy_rst_n,
    input logic phy_rst_req
);
    AST_PIN_CHANGE_MDC_LOW: assert property (@(posedge clk) disable iff (rst)
        (!$stable(mdio_o) || !$stable(mdio_oe)) |-> !mdc); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe)); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8

    AST_DONE_AFTER_GAP: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> (!$past(busy) && $past(busy, 2))); // R8

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8

    AST_PHY_RST_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> (phy_rst_n == !$past(phy_rst_req))); // R11
endmodule

bind mgmt_frame_engine mfe_checker u_mfe_chk (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .mdc(mdc),
    .mdio_oe(mdio_oe), .mdio_o(mdio_o), .phy_rst_n(phy_rst_n),
    .phy_rst_req(phy_rst_req)
);

// File: tb/tb_mgmt_frame_engine.sv
`timescale 1ns/1ps
module tb_mgmt_frame_engine;
    localparam int DIV   = 3;
    localparam int PRE   = 32;
    localparam int TOTAL = PRE + 33;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0, req_write = 1'b0, phy_rst_req = 1'b0, mdio_i = 1'b0;
    logic [4:0] req_phy = '0, req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic busy, done, mdc, mdio_oe, mdio_o, phy_rst_n;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    mgmt_frame_engine #(.DIV(DIV), .PRE_LEN(PRE)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
        .phy_rst_req(phy_rst_req), .busy(busy), .done(done), .rdata(rdata),
        .mdc(mdc), .mdio_oe(mdio_oe), .mdio_o(mdio_o), .mdio_i(mdio_i),
        .phy_rst_n(phy_rst_n)
    );

    // vectors: {write, phy, reg, wdata, phy_response}
    localparam logic [42:0] VEC [5] = '{
        {1'b0, 5'h01, 5'h02, 16'h0000, 16'hA5C3},
        {1'b1, 5'h1F, 5'h00, 16'h8001, 16'h0000},
        {1'b0, 5'h10, 5'h1F, 16'hFFFF, 16'hFFFF},
        {1'b1, 5'h0A, 5'h15, 16'h5AA5, 16'h1234},
        {1'b0, 5'h00, 5'h11, 16'h0000, 16'h0001}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_bit(input int n, input logic w, input logic [4:0] p,
                                           input logic [4:0] r, input logic [15:0] wd);
        logic [31:0] f;
        int k;
        k = n - PRE;
        if (n < PRE) return 2'b11;
        if (k >= 32) return 2'b00;
        f = {2'b01, (w ? 2'b01 : 2'b10), p, r, (w ? 2'b10 : 2'b00), (w ? wd : 16'h0)};
        if (!w && k >= 14) return 2'b00;
        return {1'b1, f[31-k]};
    endfunction

    task automatic run_txn(input logic w, input logic [4:0] p, input logic [4:0] r,
                           input logic [15:0] wd, input logic [15:0] rv,
                           input logic [15:0] exp_rdata, input bit inject);
        int nrise = 0, cyc = 0, last = 0, per_bad = 0, hi_bad = 0;
        int m_pre = 0, m_hdr = 0, m_addr = 0, m_wr = 0, m_rd = 0, m_idle = 0;
        logic prev_mdc = 1'b0, hi_o = 1'b0, hi_oe = 1'b0, pb1 = 1'b0, pb2 = 1'b0;
        bit seen = 0, gap_ok = 0, inj_on = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = w; req_phy = p; req_reg = r; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        pb1 = busy;
        prev_mdc = mdc;
        while (!seen && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (inj_on) begin
                req_valid = 1'b0;
                inj_on = 0;
            end
            if (mdc && !prev_mdc) begin
                logic [1:0] e;
                int k;
                e = exp_bit(nrise, w, p, r, wd);
                k = nrise - PRE;
                if (mdio_oe != e[1] || (e[1] && mdio_o != e[0])) begin
                    if (nrise < PRE) m_pre++;
                    else if (k < 4) m_hdr++;
                    else if (k < 14) m_addr++;
                    else if (k < 32) begin if (w) m_wr++; else m_rd++; end
                    else m_idle++;
                end
                if (nrise > 0 && (cyc - last) != 2*DIV) per_bad++;
                last = cyc;
                hi_o = mdio_o;
                hi_oe = mdio_oe;
                nrise++;
                k = nrise - PRE;
                mdio_i = (!w && k >= 16 && k < 32) ? rv[31-k] : 1'b0;
                if (inject && nrise == 10) begin
                    req_valid = 1'b1; req_write = ~w; req_phy = ~p; req_reg = ~r;
                    inj_on = 1;
                end
            end else if (mdc && (mdio_o != hi_o || mdio_oe != hi_oe)) begin
                hi_bad++;
            end
            if (done) begin
                seen = 1;
                gap_ok = (pb1 == 1'b0) && (pb2 == 1'b1);
            end
            pb2 = pb1;
            pb1 = busy;
            prev_mdc = mdc;
        end
        check(seen, "R8 done seen", int'(seen), 1);
        check(m_pre == 0, "R2 preamble bits", m_pre, 0);
        check(m_hdr == 0, "R3 start/opcode bits", m_hdr, 0);
        check(m_addr == 0, "R4 address bits", m_addr, 0);
        if (w) check(m_wr == 0, "R5 write turnaround/data", m_wr, 0);
        else   check(m_rd == 0, "R6 read line released", m_rd, 0);
        check(m_idle == 0 && nrise == TOTAL, "R8 idle bit and edge count", nrise, TOTAL);
        check(per_bad == 0, "R7 mdc period", per_bad, 0);
        check(hi_bad == 0, "R7 pins stable while mdc high", hi_bad, 0);
        check(gap_ok, "R8 busy falls one cycle before done", int'(gap_ok), 1);
        if (w) check(rdata == exp_rdata, "R10 write keeps rdata", int'(rdata), int'(exp_rdata));
        else   check(rdata == exp_rdata, "R6 read data", int'(rdata), int'(exp_rdata));
        @(negedge clk);
        check(!done, "R8 done one cycle", int'(done), 0);
        if (inject) begin
            repeat (20) @(negedge clk);
            check(!busy && !mdc, "R9 no second transaction", int'(busy), 0);
        end
    endtask

    initial begin
        #(200000 * 5.0);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] last_rd;
        repeat (3) @(negedge clk);
        check(!busy && !done && !mdc && !mdio_oe && !mdio_o, "R1 reset outputs",
              {busy, done, mdc, mdio_oe, mdio_o}, 0);
        check(phy_rst_n == 1'b0, "R11 phy reset low in reset", int'(phy_rst_n), 0);
        rst = 1'b0;
        @(negedge clk);
        check(phy_rst_n == 1'b1, "R11 phy reset released", int'(phy_rst_n), 1);
        phy_rst_req = 1'b1;
        @(negedge clk);
        check(phy_rst_n == 1'b0, "R11 phy reset requested", int'(phy_rst_n), 0);
        phy_rst_req = 1'b0;
        @(negedge clk);
        check(phy_rst_n == 1'b1, "R11 phy reset cleared", int'(phy_rst_n), 1);

        last_rd = rdata;
        for (int v = 0; v < 5; v++) begin
            logic w;
            w = VEC[v][42];
            if (!w) last_rd = VEC[v][15:0];
            run_txn(w, VEC[v][41:37], VEC[v][36:32], VEC[v][31:16], VEC[v][15:0], last_rd, 0);
        end

        // R9: conflicting request injected mid-frame
        run_txn(1'b0, 5'h05, 5'h06, 16'h0, 16'hC0DE, 16'hC0DE, 1);
        run_txn(1'b1, 5'h12, 5'h03, 16'h7E81, 16'h0, 16'hC0DE, 1);

        // R1: reset in the middle of a read
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_phy = 5'h03; req_reg = 5'h04;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        check(busy, "R1 transaction running before reset", int'(busy), 1);
        rst = 1'b1;
        @(negedge clk);
        check(!busy && !done && !mdc && !mdio_oe && !mdio_o, "R1 mid-frame reset",
              {busy, done, mdc, mdio_oe, mdio_o}, 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check(!busy && !mdc && !done, "R1 stays idle after reset", int'(busy), 0);
        run_txn(1'b0, 5'h07, 5'h08, 16'h0, 16'h8421, 16'h8421, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule